// File: doc/BRIEF.md
# Register-Triggered Multiply-Accumulate Unit

This block is a 16x16 hardware multiplier that software drives through a small register file. It has two operand registers, a five-bit mode register and a 48-bit accumulator, which is seen as three 16-bit words. Software does not issue a start command. Writes to the operand registers start the arithmetic.

The mode register sets several things:
- how many operand writes start an operation;
- whether one write is squared;
- whether the operands are two's-complement or unsigned;
- whether the product replaces the accumulator, is added to it, or is subtracted from it.

The new accumulator value is readable on the clock after the write that started the operation. Software can also write the accumulator words directly, to preload or clear it.

Top module: `mac_regunit`

## Requirements
- R1: After reset the mode register, both operand registers and all three accumulator words read as zero.
- R2: With the square bit (mode bit 4) set, a write to either operand register loads the value into both operand registers. The same write starts an operation on that value squared.
- R3: The square bit overrides the write-count bit (mode bit 3). With square set and bit 3 clear, one write still starts the operation.
- R4: With bits 4 and 3 clear, an operation starts only once both operand A and operand B have been written, in either order. A lone first write leaves the accumulator unchanged.
- R5: With bit 3 set and bit 4 clear, a write to either operand starts an operation. The operation uses the new value and the other operand's stored value.
- R6: Mode bit 0 clear treats the operands as two's-complement. Bit 0 set treats them as unsigned.
- R7: With accumulate (mode bit 1) clear, the 32-bit product goes into accumulator words 0 and 1. Word 2 takes the sign extension of the result in signed mode, and zero in unsigned mode.
- R8: With accumulate clear, negate (mode bit 2) set and signed mode, the 32-bit result is the negated product. In unsigned plain-multiply mode the negate bit has no effect.
- R9: With accumulate set, the product is added to the 48-bit accumulator when negate is clear and subtracted when negate is set. The product is sign-extended when signed and zero-extended when unsigned, and the result wraps modulo 2^48.
- R10: A write to the mode register never starts an operation. It also discards any operand write still waiting for its partner.
- R11: Each accumulator word can be written directly, and the written value reads back.
- R12: The register map is: 0 = mode, 1 = operand A, 2 = operand B, 3/4/5 = accumulator words low/middle/high. Mode bits 15..5 and the unused addresses read as zero. A result is readable one clock after the write that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register (combinational) |

## Verification
The hardest state to reach from the ports is a half-finished operand pair that is then cut off by a mode write. The next single operand write must then leave the accumulator alone. The stimulus writes operand A, rewrites the mode register, and then writes operand B, checking the accumulator after each step.

A long random phase covers the rest. It mixes mode rewrites, operand writes in both orders and direct accumulator writes. Pending-pair states therefore meet every mode combination, including square and accumulate wrap-around from preloaded extreme values.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // register addresses
   localparam int unsigned MODE_ADDR = 0;
   localparam int unsigned OPA_ADDR  = 1;
   localparam int unsigned OPB_ADDR  = 2;
   localparam int unsigned ACC_BASE  = 3;
   localparam int unsigned MODE_W    = 5;

   // mode register layout, bit 4 down to bit 0
   typedef struct packed {
      logic square;      // bit 4
      logic one_shot;    // bit 3
      logic negate;      // bit 2
      logic accum;       // bit 1
      logic unsigned_op; // bit 0
   } mode_t;
endpackage

// File: rtl/mac_trigger.sv
module mac_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_a,
   input  logic wr_b,
   input  logic wr_mode,
   input  logic square,
   input  logic one_shot,
   output logic fire,
   output logic got_a,
   output logic got_b
);
   logic any_op;

   assign any_op = wr_a | wr_b;
   assign fire   = any_op & (square | one_shot | (wr_a & got_b) | (wr_b & got_a));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_a <= 1'b0;
         got_b <= 1'b0;
      end else if (wr_mode || fire) begin
         got_a <= 1'b0;
         got_b <= 1'b0;
      end else begin
         if (wr_a) got_a <= 1'b1;
         if (wr_b) got_b <= 1'b1;
      end
   end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
   parameter int unsigned OPW = 16,
   parameter int unsigned AW  = 48
) (
   input  logic [OPW-1:0]   opa,
   input  logic [OPW-1:0]   opb,
   input  mac_pkg::mode_t   mode,
   input  logic [AW-1:0]    acc_cur,
   output logic [AW-1:0]    acc_next
);
   localparam int unsigned PW = 2 * OPW;
   localparam int unsigned XW = OPW + 1;

   logic signed [XW-1:0]   xa, xb;
   logic signed [2*XW-1:0] prod;
   logic [AW-1:0]          prod_ext;
   logic [PW-1:0]          res_lo;
   logic                   fill;
   logic [AW-1:0]          plain_val;
   logic [AW-1:0]          mac_val;

   // one extra top bit lets the same signed multiplier do both modes
   assign xa = {~mode.unsigned_op & opa[OPW-1], opa};
   assign xb = {~mode.unsigned_op & opb[OPW-1], opb};
   assign prod = xa * xb;
   assign prod_ext = AW'(prod);

   assign res_lo = (mode.negate && !mode.unsigned_op) ? (~prod[PW-1:0] + 1'b1) : prod[PW-1:0];
   assign fill   = ~mode.unsigned_op & res_lo[PW-1];

   generate
      if (AW > PW) begin : g_fill_top
         assign plain_val = {{(AW-PW){fill}}, res_lo};
      end else begin : g_no_top
         assign plain_val = res_lo[AW-1:0];
      end
   endgenerate

   assign mac_val  = mode.negate ? (acc_cur - prod_ext) : (acc_cur + prod_ext);
   assign acc_next = mode.accum ? mac_val : plain_val;
endmodule

// File: rtl/mac_regunit.sv
module mac_regunit #(
   parameter int unsigned OPW       = 16,
   parameter int unsigned ACC_WORDS = 3,
   parameter int unsigned ADDR_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [OPW-1:0]    wdata,
   output logic [OPW-1:0]    rdata
);
   import mac_pkg::*;

   localparam int unsigned AW = ACC_WORDS * OPW;
   localparam int unsigned PW = 2 * OPW;
   localparam int unsigned NREG = ACC_BASE + ACC_WORDS;

   generate
      if (AW < PW) begin : g_bad_acc
         $error("accumulator narrower than product");
      end
      if (OPW < MODE_W) begin : g_bad_opw
         $error("operand width below mode width");
      end
      if ((1 << ADDR_W) < NREG) begin : g_bad_addr
         $error("address width too small for register map");
      end
   endgenerate

   mode_t          mode_q;
   logic [OPW-1:0] op_a_q, op_b_q;
   logic [AW-1:0]  acc_q;
   logic [AW-1:0]  acc_next;
   logic [OPW-1:0] eff_a, eff_b;
   logic           wr_mode, wr_a, wr_b, fire, got_a, got_b;
   logic           load_a, load_b;

   assign wr_mode = wr_en && (addr == ADDR_W'(MODE_ADDR));
   assign wr_a    = wr_en && (addr == ADDR_W'(OPA_ADDR));
   assign wr_b    = wr_en && (addr == ADDR_W'(OPB_ADDR));
   assign load_a  = wr_a || (wr_b && mode_q.square);
   assign load_b  = wr_b || (wr_a && mode_q.square);
   assign eff_a   = load_a ? wdata : op_a_q;
   assign eff_b   = load_b ? wdata : op_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         op_a_q <= '0;
         op_b_q <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_t'(wdata[MODE_W-1:0]);
         if (load_a)  op_a_q <= wdata;
         if (load_b)  op_b_q <= wdata;
      end
   end

   mac_trigger u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_a     (wr_a),
      .wr_b     (wr_b),
      .wr_mode  (wr_mode),
      .square   (mode_q.square),
      .one_shot (mode_q.one_shot),
      .fire     (fire),
      .got_a    (got_a),
      .got_b    (got_b)
   );

   mac_datapath #(.OPW(OPW), .AW(AW)) u_dp (
      .opa      (eff_a),
      .opb      (eff_b),
      .mode     (mode_q),
      .acc_cur  (acc_q),
      .acc_next (acc_next)
   );

   generate
      for (genvar k = 0; k < ACC_WORDS; k++) begin : g_accw
         logic wr_word;
         assign wr_word = wr_en && (addr == ADDR_W'(ACC_BASE + k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       acc_q[k*OPW +: OPW] <= '0;
            else if (wr_word) acc_q[k*OPW +: OPW] <= wdata;
            else if (fire)    acc_q[k*OPW +: OPW] <= acc_next[k*OPW +: OPW];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(MODE_ADDR)) rdata = OPW'(mode_q);
      if (addr == ADDR_W'(OPA_ADDR))  rdata = op_a_q;
      if (addr == ADDR_W'(OPB_ADDR))  rdata = op_b_q;
      for (int k = 0; k < ACC_WORDS; k++) begin
         if (addr == ADDR_W'(ACC_BASE + k)) rdata = acc_q[k*OPW +: OPW];
      end
   end
endmodule

// File: rtl/mac_regunit_chk.sv
module mac_regunit_chk #(
   parameter int unsigned OPW    = 16,
   parameter int unsigned AW     = 48,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [OPW-1:0]    wdata,
   input logic [4:0]        mode,
   input logic [OPW-1:0]    op_a,
   input logic [OPW-1:0]    op_b,
   input logic [AW-1:0]     acc,
   input logic              got_a,
   input logic              got_b
);
   import mac_pkg::*;

   logic is_mode, is_a, is_b, is_acc0;
   assign is_mode = wr_en && (addr == ADDR_W'(MODE_ADDR));
   assign is_a    = wr_en && (addr == ADDR_W'(OPA_ADDR));
   assign is_b    = wr_en && (addr == ADDR_W'(OPB_ADDR));
   assign is_acc0 = wr_en && (addr == ADDR_W'(ACC_BASE));

   a_r10_mode_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      is_mode |=> $stable(acc));

   a_r10_mode_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
      is_mode |=> (!got_a && !got_b));

   a_r2_square_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_a || is_b) && mode[4]) |=> (op_a == $past(wdata) && op_b == $past(wdata)));

   a_r4_first_write_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (is_a && !mode[4] && !mode[3] && !got_b) |=> ($stable(acc) && got_a));

   a_r5_single_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((is_a || is_b) && mode[3]) |=> (!got_a && !got_b));

   a_r11_low_word_write: assert property (@(posedge clk) disable iff (!rst_n)
      is_acc0 |=> (acc[OPW-1:0] == $past(wdata)));

   a_r4_never_both_pending: assert property (@(posedge clk) disable iff (!rst_n)
      !(got_a && got_b));
endmodule

bind mac_regunit mac_regunit_chk #(.OPW(OPW), .AW(AW), .ADDR_W(ADDR_W)) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .addr  (addr),
   .wr_en (wr_en),
   .wdata (wdata),
   .mode  (mode_q),
   .op_a  (op_a_q),
   .op_b  (op_b_q),
   .acc   (acc_q),
   .got_a (got_a),
   .got_b (got_b)
);

// File: tb/mac_regunit_tb_top.sv
module mac_regunit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // reference state
   logic [4:0]  m_mode;
   logic [15:0] m_a, m_b;
   logic [47:0] m_acc;
   bit          m_fa, m_fb;

   always #5 clk = ~clk;

   mac_regunit dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
   );

   task automatic model_op();
      longint p, r;
      logic [63:0] pu;
      logic [31:0] lo;
      if (m_mode[0]) p = longint'(m_a) * longint'(m_b);
      else           p = longint'($signed(m_a)) * longint'($signed(m_b));
      pu = p;
      if (m_mode[1]) begin
         if (m_mode[2]) m_acc = m_acc - pu[47:0];
         else           m_acc = m_acc + pu[47:0];
      end else begin
         r  = (m_mode[2] && !m_mode[0]) ? -p : p;
         lo = r[31:0];
         m_acc = m_mode[0] ? {16'd0, lo} : {{16{lo[31]}}, lo};
      end
   endtask

   task automatic model_write(input int a, input logic [15:0] d);
      bit go;
      case (a)
         0: begin m_mode = d[4:0]; m_fa = 0; m_fb = 0; end
         1, 2: begin
            if (m_mode[4]) begin
               m_a = d; m_b = d; go = 1;
            end else begin
               if (a == 1) m_a = d; else m_b = d;
               go = m_mode[3] || (a == 1 ? m_fb : m_fa);
               if (!go) begin
                  if (a == 1) m_fa = 1; else m_fb = 1;
               end
            end
            if (go) begin m_fa = 0; m_fb = 0; model_op(); end
         end
         3: m_acc[15:0]  = d;
         4: m_acc[31:16] = d;
         5: m_acc[47:32] = d;
         default: ;
      endcase
   endtask

   function automatic logic [15:0] model_read(input int a);
      case (a)
         0: return {11'd0, m_mode};
         1: return m_a;
         2: return m_b;
         3: return m_acc[15:0];
         4: return m_acc[31:16];
         5: return m_acc[47:32];
         default: return 16'd0;
      endcase
   endfunction

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr  = 3'(a);
      wdata = d;
      wr_en = 1'b1;
      model_write(a, d);
   endtask

   task automatic rd_all(input string tag);
      for (int k = 0; k < 8; k++) begin
         logic [15:0] exp;
         @(negedge clk);
         wr_en = 1'b0;
         addr  = 3'(k);
         #1;
         exp = model_read(k);
         n_cmp++;
         if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, k, rdata, exp);
         end
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      m_mode = '0; m_a = '0; m_b = '0; m_acc = '0; m_fa = 0; m_fb = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_all("R1 reset");

      // R4 R6 R7: signed, both operands needed, either order
      wr(0, 16'h0000);
      wr(1, 16'hFFFD); rd_all("R4 lone A write");
      wr(2, 16'h0007); rd_all("R6 R7 signed product");
      wr(2, 16'h8000); rd_all("R4 lone B write");
      wr(1, 16'h7FFF); rd_all("R4 B then A");
      // R6 R7: unsigned
      wr(0, 16'h0001);
      wr(1, 16'hFFFF); wr(2, 16'hFFFF); rd_all("R6 R7 unsigned product");
      // R8: negate
      wr(0, 16'h0004);
      wr(1, 16'h0123); wr(2, 16'hFF00); rd_all("R8 signed negate");
      wr(0, 16'h0005);
      wr(1, 16'hFFFF); wr(2, 16'h0003); rd_all("R8 unsigned ignores negate");
      // R5: one write starts
      wr(0, 16'h0008);
      wr(1, 16'h0010); rd_all("R5 write A fires");
      wr(2, 16'hFFFE); rd_all("R5 write B fires");
      // R2 R3: square
      wr(0, 16'h0010);
      wr(2, 16'h8000); rd_all("R2 R3 square -32768");
      wr(0, 16'h0019);
      wr(1, 16'hFFFF); rd_all("R2 unsigned square");
      // R11 R9: preload then accumulate / subtract / wrap
      wr(0, 16'h0002);
      wr(3, 16'hFFFF); wr(4, 16'hFFFF); wr(5, 16'h7FFF); rd_all("R11 preload");
      wr(1, 16'h0002); wr(2, 16'h0003); rd_all("R9 signed add overflow");
      wr(3, 16'h0000); wr(4, 16'h0000); wr(5, 16'h0000); rd_all("R11 clear");
      wr(0, 16'h0006);
      wr(1, 16'h0005); wr(2, 16'h0004); rd_all("R9 subtract wraps");
      wr(0, 16'h0007);
      wr(1, 16'hFFFF); wr(2, 16'hFFFF); rd_all("R9 unsigned subtract");
      wr(0, 16'h0003);
      wr(1, 16'h8000); wr(2, 16'h8000); rd_all("R9 unsigned add");
      // R10: mode write drops pending operand
      wr(0, 16'h0000);
      wr(1, 16'h1234); rd_all("R10 pending A");
      wr(0, 16'h0000); rd_all("R10 mode write no op");
      wr(2, 16'h0011); rd_all("R10 B after drop waits");
      wr(1, 16'h0002); rd_all("R10 pair completes");
      // R12: unused addresses are covered by rd_all (6,7); write to 6 ignored
      wr(6, 16'hBEEF); rd_all("R12 unused address");

      // random mix, R2..R11
      for (int i = 0; i < 400; i++) begin
         int sel, a;
         logic [15:0] d;
         sel = $urandom_range(0, 9);
         d   = 16'($urandom);
         if (sel < 2)      a = 0;
         else if (sel < 5) a = 1;
         else if (sel < 8) a = 2;
         else              a = $urandom_range(3, 5);
         if ((i % 4) == 0) d = (d[0]) ? 16'h8000 : 16'hFFFF;
         wr(a, d);
         rd_all("R9 random mix");
      end

      finish_run();
   end
endmodule